// File: doc/BRIEF.md
# SMBus Block Transfer Buffer

This block is the byte buffer that an SMBus host controller uses for block transfers. Software reaches all of its entries through one data-port register. An internal index picks the entry. Every access through the port, read or write, moves the index forward by one. A separate count register holds the block length. A bit in the auxiliary control register switches the buffer on or off. Reading the host control register puts the index back at entry 0, so software reads control before it walks the buffer.

The transaction sequencer shares the same storage and index. On a block write, software first loads the count and the buffer. The sequencer then pulses its start input to rewind the index and pulls bytes out one per transmit request. On a block read, the first byte received from the target is the block length. A length from 1 to the buffer depth is stored in the count register and rewinds the index, and every following received byte is stored at the index. Any other length marks the transfer as failed and raises a one-cycle stop request to the sequencer.

Top module: `smbblk_buffer`

## Requirements
- R1: After reset the status, control, count and auxiliary registers read 0, the index is 0 and seq_abort is low.
- R2: Auxiliary register (offset 13) bit 1 is the buffer enable. It reads back as last written, and the other bits of that register read 0.
- R3: While the buffer is enabled, a write to the data port (offset 7) stores the byte at the index and then advances the index. A read from the data port returns the byte at the index and then advances the index.
- R4: A read of the host control register (offset 2) returns the last byte written there and resets the index to 0.
- R5: The index stops at DEPTH-1 (31 by default) and does not wrap. Further writes overwrite the last entry, and further reads keep returning it.
- R6: While the buffer is disabled, data-port writes store nothing, data-port reads return 0, and sequencer transmit and receive strobes are ignored. None of these accesses moves the index.
- R7: seq_tx_data shows the byte at the index (0 while disabled), and each seq_tx_req advances the index.
- R8: A received first byte with a value from 1 to DEPTH is written to the count register (offset 5) and resets the index to 0. The bytes received after it fill the buffer from entry 0. The count register can also be written and read by the host.
- R9: A received first byte of 0 or above DEPTH leaves the count register unchanged and sets the failed flag (status offset 0, bit 4). seq_abort goes high for exactly the following cycle. Writing 1 to status bit 4 clears the flag.
- R10: A seq_start pulse resets the index to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; read side effects occur at the clock edge |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr, combinational |
| seq_start | input | 1 | Sequencer start of block transaction; rewinds the index |
| seq_tx_req | input | 1 | Sequencer has taken seq_tx_data; advance the index |
| seq_tx_data | output | 8 | Byte at the index for transmission |
| seq_rx_valid | input | 1 | Sequencer delivers a received byte |
| seq_rx_first | input | 1 | The received byte is the block length |
| seq_rx_data | input | 8 | Received byte |
| seq_abort | output | 1 | One-cycle request to stop the transfer after a bad length |

## Verification
The bench sweeps every received length from 0 to 40, plus 255. This covers both edges of the valid range. An off-by-one check on the length would either abort a 32-byte block or accept a 33-byte one, and the bench sees that in seq_abort, the failed flag and the count read-back. It writes past the end of the buffer and reads back past the end. A wrapping index would overwrite entry 0 and show up as a mismatch there. With the buffer disabled, it writes through the port, then re-enables the buffer and reads the entries back. A design that still stored or advanced would return the wrong first entry. The bench also checks that the transmit stream starts at entry 0 after seq_start, which catches a start pulse that fails to rewind the index.

// File: rtl/smbblk_pkg.sv
package smbblk_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 4;

    // register offsets seen by the host
    localparam logic [ADDR_W-1:0] OFS_STATUS = 4'd0;
    localparam logic [ADDR_W-1:0] OFS_CTRL   = 4'd2;
    localparam logic [ADDR_W-1:0] OFS_COUNT  = 4'd5;
    localparam logic [ADDR_W-1:0] OFS_PORT   = 4'd7;
    localparam logic [ADDR_W-1:0] OFS_AUX    = 4'd13;

    localparam int STS_FAIL_BIT  = 4;
    localparam int AUX_BUFEN_BIT = 1;

    typedef struct packed {
        logic [BYTE_W-1:0] ctrl;
        logic [BYTE_W-1:0] count;
        logic              fail;
        logic              bufen;
        logic              abort;
    } regs_t;

endpackage

// File: rtl/smbblk_ptr.sv
module smbblk_ptr #(
    parameter int DEPTH = 32,
    localparam int IW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          step,
    output logic [IW-1:0] idx
);
    localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);

    logic [IW-1:0] idx_d, idx_q;

    always_comb begin
        idx_d = idx_q;
        if (clear)
            idx_d = '0;
        else if (step && idx_q != LAST)
            idx_d = idx_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) idx_q <= '0;
        else        idx_q <= idx_d;
    end

    assign idx = idx_q;
endmodule

// File: rtl/smbblk_store.sv
module smbblk_store #(
    parameter int DEPTH = 32,
    parameter int DW    = 8,
    localparam int IW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        logic [DW-1:0] ent_d;
        always_comb begin
            ent_d = mem_q[g];
            if (we && addr == IW'(g))
                ent_d = wdata;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) mem_q[g] <= '0;
            else        mem_q[g] <= ent_d;
        end
    end

    assign rdata = mem_q[addr];
endmodule

// File: rtl/smbblk_len_ok.sv
module smbblk_len_ok #(
    parameter int DEPTH = 32,
    parameter int DW    = 8
) (
    input  logic [DW-1:0] len,
    output logic          ok
);
    always_comb ok = (len != '0) && (int'(len) <= DEPTH);
endmodule

// File: rtl/smbblk_buffer.sv
module smbblk_buffer
    import smbblk_pkg::*;
#(
    parameter int DEPTH = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    input  logic              seq_start,
    input  logic              seq_tx_req,
    output logic [BYTE_W-1:0] seq_tx_data,
    input  logic              seq_rx_valid,
    input  logic              seq_rx_first,
    input  logic [BYTE_W-1:0] seq_rx_data,
    output logic              seq_abort
);
    localparam int IW = $clog2(DEPTH);

    regs_t st_d, st_q;

    logic [IW-1:0]     idx_q;
    logic [BYTE_W-1:0] mem_rdata;
    logic              len_ok;
    logic              port_wr, port_rd, ctrl_rd;
    logic              rx_first, rx_byte, tx_step;
    logic              idx_clear, idx_step;
    logic              mem_we;
    logic [BYTE_W-1:0] mem_wdata;

    // access decode
    always_comb begin
        port_wr   = reg_wr && reg_addr == OFS_PORT;
        port_rd   = reg_rd && reg_addr == OFS_PORT;
        ctrl_rd   = reg_rd && reg_addr == OFS_CTRL;
        rx_first  = st_q.bufen && seq_rx_valid && seq_rx_first;
        rx_byte   = st_q.bufen && seq_rx_valid && !seq_rx_first;
        tx_step   = st_q.bufen && seq_tx_req;
        idx_clear = ctrl_rd || seq_start || (rx_first && len_ok);
        idx_step  = st_q.bufen && (port_wr || port_rd || tx_step || rx_byte);
        mem_we    = rx_byte || (st_q.bufen && port_wr);
        mem_wdata = rx_byte ? seq_rx_data : reg_wdata;
    end

    smbblk_len_ok #(.DEPTH(DEPTH), .DW(BYTE_W)) u_len (
        .len (seq_rx_data),
        .ok  (len_ok)
    );

    smbblk_ptr #(.DEPTH(DEPTH)) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (idx_clear),
        .step  (idx_step),
        .idx   (idx_q)
    );

    smbblk_store #(.DEPTH(DEPTH), .DW(BYTE_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .addr  (idx_q),
        .wdata (mem_wdata),
        .rdata (mem_rdata)
    );

    // next register state
    always_comb begin
        st_d       = st_q;
        st_d.abort = 1'b0;
        if (reg_wr) begin
            case (reg_addr)
                OFS_CTRL:   st_d.ctrl  = reg_wdata;
                OFS_COUNT:  st_d.count = reg_wdata;
                OFS_AUX:    st_d.bufen = reg_wdata[AUX_BUFEN_BIT];
                OFS_STATUS: if (reg_wdata[STS_FAIL_BIT]) st_d.fail = 1'b0;
                default: ;
            endcase
        end
        if (rx_first) begin
            if (len_ok) begin
                st_d.count = seq_rx_data;
            end else begin
                st_d.fail  = 1'b1;
                st_d.abort = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // read mux
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_STATUS: reg_rdata[STS_FAIL_BIT]  = st_q.fail;
            OFS_CTRL:   reg_rdata                = st_q.ctrl;
            OFS_COUNT:  reg_rdata                = st_q.count;
            OFS_PORT:   reg_rdata                = st_q.bufen ? mem_rdata : '0;
            OFS_AUX:    reg_rdata[AUX_BUFEN_BIT] = st_q.bufen;
            default:    reg_rdata                = '0;
        endcase
    end

    assign seq_tx_data = st_q.bufen ? mem_rdata : '0;
    assign seq_abort   = st_q.abort;
endmodule

// File: rtl/smbblk_buffer_chk.sv
module smbblk_buffer_chk
    import smbblk_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int IW = $clog2(DEPTH)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              seq_start,
    input logic              seq_rx_valid,
    input logic              seq_rx_first,
    input logic              seq_abort,
    input logic [IW-1:0]     idx,
    input logic              bufen,
    input logic              fail
);
    localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);

    logic ctrl_rd, len_in, port_acc;
    assign ctrl_rd  = reg_rd && reg_addr == OFS_CTRL;
    assign len_in   = seq_rx_valid && seq_rx_first;
    assign port_acc = (reg_wr || reg_rd) && reg_addr == OFS_PORT;

    a_r4_ctrl_read_rewinds: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_rd |=> idx == '0);

    a_r10_start_rewinds: assert property (@(posedge clk) disable iff (!rst_n)
        seq_start |=> idx == '0);

    a_r6_disabled_holds_index: assert property (@(posedge clk) disable iff (!rst_n)
        (!bufen && !ctrl_rd && !seq_start) |=> $stable(idx));

    a_r5_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (idx == LAST && !ctrl_rd && !seq_start && !len_in) |=> idx == LAST);

    a_r3_port_advances: assert property (@(posedge clk) disable iff (!rst_n)
        (bufen && port_acc && idx != LAST && !seq_start && !len_in)
        |=> idx == IW'($past(idx) + 1'b1));

    a_r9_abort_has_fail: assert property (@(posedge clk) disable iff (!rst_n)
        seq_abort |-> fail);
endmodule

bind smbblk_buffer smbblk_buffer_chk #(.DEPTH(DEPTH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr       (reg_wr),
    .reg_rd       (reg_rd),
    .reg_addr     (reg_addr),
    .seq_start    (seq_start),
    .seq_rx_valid (seq_rx_valid),
    .seq_rx_first (seq_rx_first),
    .seq_abort    (seq_abort),
    .idx          (idx_q),
    .bufen        (st_q.bufen),
    .fail         (st_q.fail)
);

// File: tb/smbblk_buffer_test.sv
module smbblk_buffer_test;
    localparam int DEPTH = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [3:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       seq_start = 1'b0, seq_tx_req = 1'b0;
    logic [7:0] seq_tx_data;
    logic       seq_rx_valid = 1'b0, seq_rx_first = 1'b0;
    logic [7:0] seq_rx_data = '0;
    logic       seq_abort;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    smbblk_buffer #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .seq_start(seq_start), .seq_tx_req(seq_tx_req), .seq_tx_data(seq_tx_data),
        .seq_rx_valid(seq_rx_valid), .seq_rx_first(seq_rx_first),
        .seq_rx_data(seq_rx_data), .seq_abort(seq_abort)
    );

    function automatic logic [7:0] pat(int s, int i);
        return 8'((i * 37 + s * 11 + 5) & 255);
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic wr(logic [3:0] a, logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [7:0] d);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic rx(logic first, logic [7:0] d);
        seq_rx_valid = 1'b1; seq_rx_first = first; seq_rx_data = d;
        @(negedge clk);
        seq_rx_valid = 1'b0; seq_rx_first = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int exp_cnt;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(4'd0, v);  chk("R1 status", v, 0);
        rd(4'd2, v);  chk("R1 ctrl", v, 0);
        rd(4'd5, v);  chk("R1 count", v, 0);
        rd(4'd13, v); chk("R1 aux", v, 0);
        chk("R1 abort", seq_abort, 0);

        // R2 enable bit read-back
        wr(4'd13, 8'hFF); rd(4'd13, v); chk("R2 aux all ones", v, 2);
        wr(4'd13, 8'h00); rd(4'd13, v); chk("R2 aux cleared", v, 0);
        wr(4'd13, 8'h02); rd(4'd13, v); chk("R2 aux enable", v, 2);

        // R1 index starts at 0: first write lands in entry 0
        for (int i = 0; i < DEPTH; i++) wr(4'd7, pat(1, i));
        wr(4'd2, 8'h5A);
        rd(4'd2, v); chk("R4 ctrl read-back", v, 8'h5A);
        for (int i = 0; i < DEPTH; i++) begin
            rd(4'd7, v); chk("R3 port readback", v, pat(1, i));
        end
        // R4 rewind in mid-walk
        rd(4'd2, v);
        for (int i = 0; i < 5; i++) rd(4'd7, v);
        rd(4'd2, v);
        rd(4'd7, v); chk("R4 rewind to entry 0", v, pat(1, 0));
        rd(4'd7, v); chk("R4 then entry 1", v, pat(1, 1));

        // R5 saturation
        rd(4'd2, v);
        for (int i = 0; i < 40; i++) wr(4'd7, pat(2, i));
        rd(4'd2, v);
        for (int i = 0; i < DEPTH - 1; i++) begin
            rd(4'd7, v); chk("R5 low entries", v, pat(2, i));
        end
        for (int i = 0; i < 4; i++) begin
            rd(4'd7, v); chk("R5 last entry sticks", v, pat(2, 39));
        end

        // R6 disabled buffer
        wr(4'd13, 8'h00);
        rd(4'd2, v);
        for (int i = 0; i < 3; i++) wr(4'd7, 8'hAA);
        rd(4'd7, v); chk("R6 disabled read is zero", v, 0);
        #1 chk("R7 tx data zero while disabled", seq_tx_data, 0);
        seq_tx_req = 1'b1; @(negedge clk); seq_tx_req = 1'b0;
        rx(1'b0, 8'hCC);
        wr(4'd13, 8'h02);
        rd(4'd7, v); chk("R6 entry 0 untouched", v, pat(2, 0));
        rd(4'd7, v); chk("R6 entry 1 untouched", v, pat(2, 1));

        // R7 and R10 transmit drain
        rd(4'd2, v);
        for (int i = 0; i < 10; i++) wr(4'd7, pat(3, i));
        seq_start = 1'b1; @(negedge clk); seq_start = 1'b0;
        for (int i = 0; i < 10; i++) begin
            #1 chk("R7 tx stream", seq_tx_data, pat(3, i));
            seq_tx_req = 1'b1; @(negedge clk); seq_tx_req = 1'b0;
        end
        seq_start = 1'b1; @(negedge clk); seq_start = 1'b0;
        #1 chk("R10 start rewinds", seq_tx_data, pat(3, 0));

        // R8 host access to count
        wr(4'd5, 8'h55); rd(4'd5, v); chk("R8 count host rw", v, 8'h55);
        exp_cnt = 8'h55;

        // R8 and R9 length sweep
        for (int c = 0; c <= 41; c++) begin
            int len = (c == 41) ? 255 : c;
            rx(1'b1, 8'(len));
            if (len >= 1 && len <= DEPTH) begin
                chk("R9 no abort on good length", seq_abort, 0);
                exp_cnt = len;
                rd(4'd5, v); chk("R8 count stored", v, exp_cnt);
                for (int i = 0; i < len; i++) rx(1'b0, pat(c + 10, i));
                rd(4'd2, v);
                for (int i = 0; i < len; i++) begin
                    rd(4'd7, v); chk("R8 received bytes", v, pat(c + 10, i));
                end
                rd(4'd0, v); chk("R9 no fail on good length", v, 0);
            end else begin
                chk("R9 abort pulse", seq_abort, 1);
                @(negedge clk);
                chk("R9 abort one cycle", seq_abort, 0);
                rd(4'd0, v); chk("R9 fail flag", v, 8'h10);
                rd(4'd5, v); chk("R9 count kept", v, exp_cnt);
                wr(4'd0, 8'h10);
                rd(4'd0, v); chk("R9 fail cleared", v, 0);
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule